// File: doc/BRIEF.md
# Edge-Selectable GPIO Interrupt Port

This block is an eight-line general-purpose I/O port. Software reaches it over a simple register bus that holds three registers. The data register holds the value each line drives. The direction register decides, bit by bit, whether a line is a high-impedance input or a driven output. The edge register picks which transition of each line's input raises an interrupt event. On the pin side the block gives a per-bit output value and output enable. It also brings out the synchronized input it sees.

Interrupt events come from one falling-edge detector per line. That detector watches the XOR of the synchronized input with the line's edge bit. Because of this, rewriting an edge bit while the input is steady can raise an event on its own. Each event is a single-clock pulse and is passed out only when the matching channel enable input is high. Pending, masking and vector logic downstream are expected to latch it.

Top module: `gpio_edge_port`

## Requirements
- R1: On synchronous reset (`rst` high) the data, edge and direction registers clear to zero. The first cycle after reset shows `pin_out`=0, `pin_oe`=0 and no `edge_evt` bit.
- R2: A write at address 2 loads the direction register. `pin_oe[i]`=1 (bit value 1) makes line i a driven output, and 0 makes it a high-impedance input.
- R3: A write at address 0 loads the data register for every line, whatever its direction. `pin_out` always shows the stored bits, and the pins are only driven where `pin_oe` is 1.
- R4: A read at address 0 returns, for each bit, the stored data bit where the direction bit is 1 and the synchronized pin value where it is 0.
- R5: Reads at address 1 return the edge register and reads at address 2 return the direction register. Any other address reads as zero. Reads are combinational from `addr`.
- R6: `pin_sync` follows `pin_in` through a two-flop synchronizer, so it lags by exactly two clocks.
- R7: With edge bit 0, a high-to-low change of a line's synchronized input gives exactly one single-cycle `edge_evt` pulse on that line. The pulse appears in the first cycle in which `pin_sync` shows the new value.
- R8: With edge bit 1, a low-to-high change of the synchronized input gives exactly one single-cycle pulse, and a high-to-low change gives none.
- R9: With the input steady, rewriting an edge bit so that the XOR of input and edge bit goes from 1 to 0 gives one event. A rewrite that takes that XOR from 0 to 1 gives none.
- R10: An `edge_evt` bit can be high only while the matching `chan_en` bit is high. An edge that occurs while the channel is disabled is dropped and is not reported later.
- R11: A write takes effect on the rising clock edge at which `wr_en` is high. Before that edge the outputs keep their old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (2) | Register select: 0 data, 1 edge, 2 direction |
| wr_data | input | WIDTH (8) | Write data |
| rd_data | output | WIDTH (8) | Combinational read data |
| pin_in | input | WIDTH (8) | Raw pin input levels |
| pin_out | output | WIDTH (8) | Per-line output value |
| pin_oe | output | WIDTH (8) | Per-line output enable (1 = drive) |
| pin_sync | output | WIDTH (8) | Synchronized pin input |
| chan_en | input | WIDTH (8) | Per-channel event enable |
| edge_evt | output | WIDTH (8) | Per-channel single-cycle event pulse |

## Verification
A wrong edge register or a stale previous-XOR bit does not show on the pins until a line's input or edge bit changes. At that point it appears in the same cycle as a missing, extra or repeated `edge_evt` pulse, or as a wrong edge-register readback. A wrong direction or data bit shows at `pin_oe`, `pin_out` and the address-0 readback in the cycle right after the write. A synchronizer fault shifts `pin_sync` and every later event by one or more cycles. For that reason the outputs are compared against a reference model on every clock, and the counts of event pulses per channel are checked after each scenario.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   // register select codes on the bus
   localparam int unsigned SEL_DATA = 0;
   localparam int unsigned SEL_EDGE = 1;
   localparam int unsigned SEL_DIR  = 2;
   // minimum synchronizer depth
   localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   import gpio_edge_pkg::*;

   if (STAGES < MIN_SYNC) begin : g_bad_depth
      $error("gpio_sync: STAGES must be at least %0d", MIN_SYNC);
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            stage_q[s] <= '0;
         end else begin
            if (s == 0) stage_q[s] <= async_in;
            else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wr_data,
   input  logic [WIDTH-1:0]  sync_in,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  edge_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  rd_data
);
   import gpio_edge_pkg::*;

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(SEL_DATA);
   localparam logic [ADDR_W-1:0] A_EDGE = ADDR_W'(SEL_EDGE);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(SEL_DIR);

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q <= '0;
         edge_q <= '0;
         dir_q  <= '0;
      end else if (wr_en) begin
         if (addr == A_DATA) data_q <= wr_data;
         if (addr == A_EDGE) edge_q <= wr_data;
         if (addr == A_DIR)  dir_q  <= wr_data;
      end
   end

   // per-bit mix: latched value on outputs, pin on inputs
   logic [WIDTH-1:0] port_view;
   for (genvar i = 0; i < WIDTH; i++) begin : g_mix
      assign port_view[i] = dir_q[i] ? data_q[i] : sync_in[i];
   end

   always_comb begin
      rd_data = '0;
      if (addr == A_DATA)      rd_data = port_view;
      else if (addr == A_EDGE) rd_data = edge_q;
      else if (addr == A_DIR)  rd_data = dir_q;
   end
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] sync_in,
   input  logic [WIDTH-1:0] polarity,
   input  logic [WIDTH-1:0] chan_en,
   output logic [WIDTH-1:0] evt
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      logic level_now;
      logic level_prev;

      assign level_now = sync_in[i] ^ polarity[i];

      // cleared to 0 so the first cycle after reset cannot look like a fall
      always_ff @(posedge clk) begin
         if (rst) level_prev <= 1'b0;
         else     level_prev <= level_now;
      end

      assign evt[i] = level_prev & ~level_now & chan_en[i];
   end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wr_data,
   output logic [WIDTH-1:0]  rd_data,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pin_sync,
   input  logic [WIDTH-1:0]  chan_en,
   output logic [WIDTH-1:0]  edge_evt
);
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_edge_port: WIDTH must be positive");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("gpio_edge_port: ADDR_W must cover three registers");
   end

   logic [WIDTH-1:0] sync_w;
   logic [WIDTH-1:0] data_w;
   logic [WIDTH-1:0] edge_w;
   logic [WIDTH-1:0] dir_w;

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (pin_in),
      .sync_out (sync_w)
   );

   gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .addr    (addr),
      .wr_data (wr_data),
      .sync_in (sync_w),
      .data_q  (data_w),
      .edge_q  (edge_w),
      .dir_q   (dir_w),
      .rd_data (rd_data)
   );

   gpio_edge_det #(.WIDTH(WIDTH)) u_edge (
      .clk      (clk),
      .rst      (rst),
      .sync_in  (sync_w),
      .polarity (edge_w),
      .chan_en  (chan_en),
      .evt      (edge_evt)
   );

   assign pin_out  = data_w;
   assign pin_oe   = dir_w;
   assign pin_sync = sync_w;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [WIDTH-1:0]  wr_data,
   input logic [WIDTH-1:0]  rd_data,
   input logic [WIDTH-1:0]  pin_in,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  pin_sync,
   input logic [WIDTH-1:0]  chan_en,
   input logic [WIDTH-1:0]  edge_evt
);
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && edge_evt == '0));

   p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(2)) |=> pin_oe == $past(wr_data));

   p_data_write_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(0)) |=> pin_out == $past(wr_data));

   p_data_read_r4: assert property (@(posedge clk) disable iff (rst)
      (addr == ADDR_W'(0)) |-> rd_data == ((pin_out & pin_oe) | (pin_sync & ~pin_oe)));

   p_dir_read_r5: assert property (@(posedge clk) disable iff (rst)
      (addr == ADDR_W'(2)) |-> rd_data == pin_oe);

   p_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (addr > ADDR_W'(2)) |-> rd_data == '0);

   if (SYNC_STAGES == 2) begin : g_lag
      p_sync_lag_r6: assert property (@(posedge clk) disable iff (rst)
         (since_rst >= 2'd2) |-> pin_sync == $past(pin_in, 2));
   end

   p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      (|edge_evt && !wr_en) |=> (!$stable(pin_sync) || edge_evt == '0));

   p_enable_gate_r10: assert property (@(posedge clk) disable iff (rst)
      (edge_evt & ~chan_en) == '0);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(
   .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
   .pin_sync(pin_sync), .chan_en(chan_en), .edge_evt(edge_evt)
);

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
   localparam int W  = 8;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [W-1:0]  pin_in = '0;
   logic [W-1:0]  chan_en = '0;
   logic [W-1:0]  rd_data, pin_out, pin_oe, pin_sync, edge_evt;

   always #10 clk = ~clk;

   gpio_edge_port u_gpio_edge_port (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pin_sync(pin_sync), .chan_en(chan_en), .edge_evt(edge_evt)
   );

   int checks = 0;
   int errors = 0;
   int ev_cnt [W];
   int snap   [W];

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference state, advanced once per rising edge
   logic [W-1:0] m_data = '0, m_edge = '0, m_dir = '0;
   logic [W-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_data = '0; m_edge = '0; m_dir = '0;
         m_s1 = '0; m_s2 = '0; m_prev = '0;
      end else begin
         m_prev = m_s2 ^ m_edge;
         m_s2   = m_s1;
         m_s1   = pin_in;
         if (wr_en) begin
            case (addr)
               2'd0: m_data = wr_data;
               2'd1: m_edge = wr_data;
               2'd2: m_dir  = wr_data;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [W-1:0] exp_read();
      case (addr)
         2'd0: return (m_data & m_dir) | (m_s2 & ~m_dir);
         2'd1: return m_edge;
         2'd2: return m_dir;
         default: return '0;
      endcase
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!rst) begin
         chk("R3 pin_out", pin_out, m_data);
         chk("R2 pin_oe", pin_oe, m_dir);
         chk("R6 pin_sync", pin_sync, m_s2);
         chk("R4 R5 rd_data", rd_data, exp_read());
         chk("R7 R8 R9 R10 edge_evt", edge_evt, m_prev & ~(m_s2 ^ m_edge) & chan_en);
         for (int i = 0; i < W; i++) if (edge_evt[i]) ev_cnt[i]++;
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin
         @(posedge clk);
         #5;
      end
   endtask

   task automatic look();
      #7;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [W-1:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic take_snap();
      for (int i = 0; i < W; i++) snap[i] = ev_cnt[i];
   endtask

   task automatic chk_events(string tag, logic [W-1:0] exp_mask);
      logic [W-1:0] seen, multi;
      for (int i = 0; i < W; i++) begin
         seen[i]  = (ev_cnt[i] - snap[i]) != 0;
         multi[i] = (ev_cnt[i] - snap[i]) > 1;
      end
      chk({tag, " event lines"}, seen, exp_mask);
      chk({tag, " repeated pulses"}, multi, '0);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < W; i++) begin ev_cnt[i] = 0; snap[i] = 0; end
      pin_in  = 8'hA5;
      chan_en = 8'hFF;
      step(3);
      rst = 1'b0;
      look();
      // R1: cleared state in the first cycle after reset
      chk("R1 pin_out", pin_out, 8'h00);
      chk("R1 pin_oe", pin_oe, 8'h00);
      chk("R1 edge_evt", edge_evt, 8'h00);
      step(3);

      // R11: write not visible before its edge
      wr_en = 1'b1; addr = 2'd0; wr_data = 8'h3C;
      look();
      chk("R11 pin_out before edge", pin_out, 8'h00);
      step();
      wr_en = 1'b0;
      look();
      chk("R11 pin_out after edge", pin_out, 8'h3C);
      step();
      wr(2'd2, 8'h0F);
      look();
      chk("R2 pin_oe", pin_oe, 8'h0F);
      chk("R3 pin_out kept", pin_out, 8'h3C);
      // R4: mixed readback
      addr = 2'd0;
      step();
      look();
      chk("R4 mixed read", rd_data, 8'hAC);
      step();

      // R5: edge/direction readback and unused address
      wr(2'd1, 8'h81);
      addr = 2'd1; look(); chk("R5 edge read", rd_data, 8'h81); step();
      addr = 2'd2; look(); chk("R5 dir read", rd_data, 8'h0F); step();
      addr = 2'd3; look(); chk("R5 unused read", rd_data, 8'h00); step();
      wr(2'd1, 8'h00);
      addr = 2'd0;
      step(3);

      // R6 and R7: falling edges with edge bits 0
      take_snap();
      pin_in = 8'h00;
      step(); look();
      chk("R6 pin_sync one clock", pin_sync, 8'hA5);
      step(); look();
      chk("R6 pin_sync two clocks", pin_sync, 8'h00);
      chk("R7 pulse timing", edge_evt, 8'hA5);
      step(); look();
      chk("R7 pulse ends", edge_evt, 8'h00);
      step(3);
      chk_events("R7", 8'hA5);

      // R8: rising edges with edge bits 1
      wr(2'd1, 8'hFF);
      step(2);
      take_snap();
      pin_in = 8'h0F;
      step(5);
      pin_in = 8'h00;
      step(5);
      chk_events("R8", 8'h0F);

      // R9: edge-bit rewrite with steady input
      pin_in = 8'h0F;
      step(5);
      take_snap();
      wr(2'd1, 8'h00);
      step(3);
      chk_events("R9 rewrite to 0", 8'hF0);
      take_snap();
      wr(2'd1, 8'hFF);
      step(3);
      chk_events("R9 rewrite to 1", 8'h0F);

      // R10: disabled channels drop their edges
      chan_en = 8'h00;
      take_snap();
      pin_in = 8'hFF;
      step(5);
      chan_en = 8'hFF;
      step(3);
      chk_events("R10 disabled", 8'h00);
      chan_en = 8'h3C;
      wr(2'd1, 8'h00);
      take_snap();
      pin_in = 8'h00;
      step(5);
      chk_events("R10 partial enable", 8'h3C);

      finish_run();
   end
endmodule